// File: doc/BRIEF.md
# Four-Operation Load/Store Processor Core

This block is a small single-cycle processor. Each rising clock edge it fetches the 16-bit word at the program counter and executes it completely. An 8-bit data path serves four general registers, X0 to X3. The four operations are register add, register subtract, load from data memory and store to data memory. Memory addresses are formed as a base register plus an 8-bit unsigned offset.

A decoder turns the 2-bit operation code into a packed 8-bit control word. One bit of that word steers the second register read port to the destination field, so that a store can read the value it must write out. The instruction memory and the data memory are both held inside the core. Each has a preload port that an external agent uses only while reset is held, to place the program and the initial data. A combinational debug port lets any register be read at any time, so a reference model can be compared against the core after every instruction.

Top module: `tiny_core`

## Requirements
- R1: While `rst` (active high, synchronous) is sampled high at a rising edge, the program counter and all four registers become 0.
- R2: After reset the program counter `pc_o` increases by one at every rising edge, wrapping from 255 to 0, and each edge executes the instruction stored at the old counter value.
- R3: Instruction bits [15:14] hold the operation code (00 load, 01 store, 10 subtract, 11 add), [13:12] the destination Rd, [11:10] the base/first source Rn, [9:8] the second source Rm and [7:0] the unsigned offset imm8. Add writes (Rn + Rm) mod 256 to Rd, and imm8 has no effect.
- R4: Subtract writes (Rn - Rm) mod 256 to Rd, and imm8 has no effect.
- R5: Load writes the data memory word at (Rn + imm8) mod 256 into Rd, and the Rm field has no effect.
- R6: Store writes the value of Rd to data memory at (Rn + imm8) mod 256 and leaves all registers unchanged. The stored value is returned by a later load of that address.
- R7: All operands are read before the edge that writes the result. The same register may therefore appear in any combination of the Rd, Rn and Rm fields of one instruction.
- R8: The instruction and data preload ports write their memories at a rising edge only while `rst` is high. While `rst` is low they are ignored.
- R9: `dbg_data` shows, without a clock delay, the current value of the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables the preload ports |
| imem_ld_we | input | 1 | Instruction memory preload write enable |
| imem_ld_addr | input | 8 | Instruction memory preload address |
| imem_ld_data | input | 16 | Instruction word to preload |
| dmem_ld_we | input | 1 | Data memory preload write enable |
| dmem_ld_addr | input | 8 | Data memory preload address |
| dmem_ld_data | input | 8 | Data word to preload |
| dbg_sel | input | 2 | Register index for the debug read port |
| dbg_data | output | 8 | Value of the selected register |
| pc_o | output | 8 | Current program counter |

## Verification
The assertions assume that reset is held for at least one edge before the core runs. They also assume that every instruction word it fetches is fully defined, so that the decoded destination index and the memory address are known values when the write-back checks look at them. The stimulus meets both assumptions. It holds reset for the whole preload phase, writes all 256 locations of both memories before release, and releases reset only away from a clock edge. While the core runs, the bench drives conflicting preload writes, including one to an address the program stores to and loads from, so that the reset gating of the preload ports is tested at the core's ports.

// File: rtl/tcore_pkg.sv
package tcore_pkg;

    parameter int unsigned XLEN       = 8;
    parameter int unsigned ILEN       = 16;
    parameter int unsigned NREG       = 4;
    parameter int unsigned IMM_W      = 8;
    parameter int unsigned IMEM_DEPTH = 256;
    parameter int unsigned DMEM_DEPTH = 256;

    localparam int unsigned RIDX = $clog2(NREG);
    localparam int unsigned IAW  = $clog2(IMEM_DEPTH);
    localparam int unsigned DAW  = $clog2(DMEM_DEPTH);

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [ILEN-1:0]  insn_t;
    typedef logic [RIDX-1:0]  ridx_t;
    typedef logic [IMM_W-1:0] imm_t;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_SUB   = 2'b10,
        OP_ADD   = 2'b11
    } opcode_e;

    // Field order is fixed by the instruction encoding (MSB first).
    typedef struct packed {
        opcode_e op;
        ridx_t   rd;
        ridx_t   rn;
        ridx_t   rm;
        imm_t    imm;
    } insn_fields_t;

    // Packed control word, MSB first; the bit order matches the encoding.
    typedef struct packed {
        logic rsel_dst;   // second read port takes Rd instead of Rm
        logic reg_we;     // write result to Rd
        logic alu_sub;    // 1: subtract, 0: add
        logic use_imm;    // second ALU operand is the offset
        logic mem_we;     // data memory write
        logic mem_re;     // data memory read
        logic wb_mem;     // write-back takes memory data
        logic pad;        // always zero
    } ctrl_t;

    function automatic ctrl_t ctrl_of(opcode_e op);
        ctrl_t c;
        case (op)
            OP_LOAD:  c = 8'b1101_0110;
            OP_STORE: c = 8'b1001_1000;
            OP_ADD:   c = 8'b0100_0000;
            default:  c = 8'b0110_0000;
        endcase
        return c;
    endfunction

    function automatic word_t zext_imm(imm_t v);
        return word_t'(v);
    endfunction

endpackage

// File: rtl/tcore_ram.sv
module tcore_ram #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R6: a write is visible at its address after the edge
    p_ram_write_r6: assert property (@(posedge clk)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/tcore_decode.sv
module tcore_decode
    import tcore_pkg::*;
(
    input  insn_t  insn,
    output opcode_e op,
    output ridx_t  rd,
    output ridx_t  rn,
    output ridx_t  rb_idx,
    output word_t  imm_ext,
    output ctrl_t  ctrl
);

    insn_fields_t f;

    always_comb begin
        f       = insn_fields_t'(insn);
        op      = f.op;
        rd      = f.rd;
        rn      = f.rn;
        ctrl    = ctrl_of(f.op);
        rb_idx  = ctrl.rsel_dst ? f.rd : f.rm;
        imm_ext = zext_imm(f.imm);
    end

endmodule

// File: rtl/tcore_regfile.sv
module tcore_regfile
    import tcore_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  ridx_t                 ra_a,
    input  ridx_t                 ra_b,
    output word_t                 rdata_a,
    output word_t                 rdata_b,
    input  logic                  we,
    input  ridx_t                 wa,
    input  word_t                 wd,
    output logic [NREG-1:0][XLEN-1:0] regs_o
);

    word_t regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (we && wa == ridx_t'(i)) begin
                regs_q[i] <= wd;
            end
        end
        assign regs_o[i] = regs_q[i];
    end

    assign rdata_a = regs_q[ra_a];
    assign rdata_b = regs_q[ra_b];

    // R1: reset clears every register
    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> regs_o == '0);

    // R6: without a write enable no register changes
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !we |=> regs_o == $past(regs_o));

endmodule

// File: rtl/tcore_alu.sv
module tcore_alu
    import tcore_pkg::*;
(
    input  word_t a,
    input  word_t b,
    input  logic  sub,
    output word_t y
);

    always_comb begin
        if (sub) begin
            y = a - b;
        end else begin
            y = a + b;
        end
    end

endmodule

// File: rtl/tiny_core.sv
module tiny_core
    import tcore_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             imem_ld_we,
    input  logic [IAW-1:0]   imem_ld_addr,
    input  logic [ILEN-1:0]  imem_ld_data,
    input  logic             dmem_ld_we,
    input  logic [DAW-1:0]   dmem_ld_addr,
    input  logic [XLEN-1:0]  dmem_ld_data,
    input  logic [RIDX-1:0]  dbg_sel,
    output logic [XLEN-1:0]  dbg_data,
    output logic [IAW-1:0]   pc_o
);

    localparam logic [IAW-1:0] PC_LAST = IAW'(IMEM_DEPTH - 1);

    logic [IAW-1:0] pc;
    insn_t          insn;
    opcode_e        op;
    ridx_t          rd, rn, rb_idx;
    word_t          imm_ext;
    ctrl_t          ctrl;
    word_t          rdata_a, rdata_b, alu_b, alu_y, wb_data;
    word_t          dmem_rdata;
    logic [NREG-1:0][XLEN-1:0] regs_w;
    logic           dmem_we;
    logic [DAW-1:0] dmem_waddr;
    word_t          dmem_wdata;
    logic           ctrl_pad_unused;

    // program counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (pc == PC_LAST) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    assign pc_o = pc;

    // instruction memory: preload only during reset
    tcore_ram #(.WIDTH(ILEN), .DEPTH(IMEM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (rst && imem_ld_we),
        .waddr (imem_ld_addr),
        .wdata (imem_ld_data),
        .raddr (pc),
        .rdata (insn)
    );

    tcore_decode u_dec (
        .insn    (insn),
        .op      (op),
        .rd      (rd),
        .rn      (rn),
        .rb_idx  (rb_idx),
        .imm_ext (imm_ext),
        .ctrl    (ctrl)
    );

    assign ctrl_pad_unused = ctrl.pad;

    tcore_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_a    (rn),
        .ra_b    (rb_idx),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b),
        .we      (ctrl.reg_we),
        .wa      (rd),
        .wd      (wb_data),
        .regs_o  (regs_w)
    );

    assign alu_b = ctrl.use_imm ? imm_ext : rdata_b;

    tcore_alu u_alu (
        .a   (rdata_a),
        .b   (alu_b),
        .sub (ctrl.alu_sub),
        .y   (alu_y)
    );

    // data memory: preload port owns the write side during reset
    always_comb begin
        if (rst) begin
            dmem_we    = dmem_ld_we;
            dmem_waddr = dmem_ld_addr;
            dmem_wdata = dmem_ld_data;
        end else begin
            dmem_we    = ctrl.mem_we;
            dmem_waddr = alu_y[DAW-1:0];
            dmem_wdata = rdata_b;
        end
    end

    tcore_ram #(.WIDTH(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (alu_y[DAW-1:0]),
        .rdata (dmem_rdata)
    );

    assign wb_data  = (ctrl.wb_mem && ctrl.mem_re) ? dmem_rdata : alu_y;
    assign dbg_data = regs_w[dbg_sel];

    // R2: counter steps by one
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pc != PC_LAST) |=> pc == $past(pc) + 1'b1);

    // R2: counter wraps to zero after the last word
    p_pc_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (pc == PC_LAST) |=> pc == '0);

    // R3: add result lands in the destination
    p_add_wb_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD) |=> regs_w[$past(rd)] == word_t'($past(rdata_a) + $past(rdata_b)));

    // R4: subtract result lands in the destination
    p_sub_wb_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUB) |=> regs_w[$past(rd)] == word_t'($past(rdata_a) - $past(rdata_b)));

    // R5: load writes the memory word into the destination
    p_load_wb_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> regs_w[$past(rd)] == $past(dmem_rdata));

endmodule

// File: tb/tiny_core_bench.sv
module tiny_core_bench;

    localparam time CLK_PERIOD = 20ns;
    localparam int  NSTEPS     = 300;

    typedef struct packed {
        logic [7:0]  pcn;
        logic [31:0] regs;
        logic [1:0]  op;
        logic        rep;
        logic        late;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_ld_we = 1'b0;
    logic [7:0]  imem_ld_addr = '0;
    logic [15:0] imem_ld_data = '0;
    logic        dmem_ld_we = 1'b0;
    logic [7:0]  dmem_ld_addr = '0;
    logic [7:0]  dmem_ld_data = '0;
    logic [1:0]  dbg_sel = '0;
    logic [7:0]  dbg_data;
    logic [7:0]  pc_o;

    int   checks = 0;
    int   failures = 0;
    bit   mon_en = 1'b0;
    bit   finished = 1'b0;
    exp_t q [$];

    logic [15:0] m_imem [256];
    logic [7:0]  m_dmem [256];
    logic [7:0]  m_reg  [4];
    logic [7:0]  m_pc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tiny_core u_tiny_core (
        .clk          (clk),
        .rst          (rst),
        .imem_ld_we   (imem_ld_we),
        .imem_ld_addr (imem_ld_addr),
        .imem_ld_data (imem_ld_data),
        .dmem_ld_we   (dmem_ld_we),
        .dmem_ld_addr (dmem_ld_addr),
        .dmem_ld_data (dmem_ld_data),
        .dbg_sel      (dbg_sel),
        .dbg_data     (dbg_data),
        .pc_o         (pc_o)
    );

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    function automatic logic [15:0] enc(input logic [1:0] op, input logic [1:0] rd,
                                        input logic [1:0] rn, input logic [1:0] rm,
                                        input logic [7:0] imm);
        return {op, rd, rn, rm, imm};
    endfunction

    // reference model: one instruction, then push the expected state (driver)
    task automatic drive_step(input int step);
        logic [15:0] ins;
        logic [1:0]  op, rd, rn, rm;
        logic [7:0]  imm, a, addr;
        exp_t        e;
        ins  = m_imem[m_pc];
        op   = ins[15:14];
        rd   = ins[13:12];
        rn   = ins[11:10];
        rm   = ins[9:8];
        imm  = ins[7:0];
        a    = m_reg[rn];
        addr = a + imm;
        case (op)
            2'b00: m_reg[rd] = m_dmem[addr];
            2'b01: m_dmem[addr] = m_reg[rd];
            2'b10: m_reg[rd] = a - m_reg[rm];
            default: m_reg[rd] = a + m_reg[rm];
        endcase
        m_pc   = m_pc + 8'd1;
        e.pcn  = m_pc;
        e.regs = {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
        e.op   = op;
        e.rep  = (rd == rn) || (op[1] && (rn == rm || rd == rm));
        e.late = (step >= 256);
        q.push_back(e);
    endtask

    // monitor: compare the core against each expected item after its edge
    always @(negedge clk) begin
        if (mon_en && q.size() != 0) begin
            exp_t  e;
            string tag;
            e = q.pop_front();
            case (e.op)
                2'b00: tag = "R5";
                2'b01: tag = "R6";
                2'b10: tag = "R4";
                default: tag = "R3";
            endcase
            tag = $sformatf("%s%s%s/R9", tag, e.rep ? "/R7" : "", e.late ? "/R8" : "");
            chk("R2 pc", int'(pc_o), int'(e.pcn));
            for (int s = 0; s < 4; s++) begin
                dbg_sel = 2'(s);
                #1;
                chk($sformatf("%s X%0d", tag, s), int'(dbg_data), int'(e.regs[s*8 +: 8]));
            end
        end
    end

    task automatic check_zero(input string tag);
        chk({tag, " pc"}, int'(pc_o), 0);
        for (int s = 0; s < 4; s++) begin
            dbg_sel = 2'(s);
            #1;
            chk($sformatf("%s X%0d", tag, s), int'(dbg_data), 0);
        end
    endtask

    initial begin
        logic [31:0] lcg;
        // program: directed head, pseudo-random tail
        m_imem[0]  = enc(2'b00, 2'd1, 2'd0, 2'd3, 8'h10); // load, Rm ignored (R5)
        m_imem[1]  = enc(2'b00, 2'd2, 2'd0, 2'd0, 8'h11);
        m_imem[2]  = enc(2'b11, 2'd3, 2'd2, 2'd2, 8'hA5); // add, imm ignored, wraps (R3, R7)
        m_imem[3]  = enc(2'b10, 2'd0, 2'd1, 2'd2, 8'h5A); // sub wraps (R4)
        m_imem[4]  = enc(2'b01, 2'd3, 2'd1, 2'd3, 8'h20); // store (R6)
        m_imem[5]  = enc(2'b00, 2'd0, 2'd1, 2'd2, 8'h20); // load back (R6)
        m_imem[6]  = enc(2'b11, 2'd1, 2'd1, 2'd1, 8'h00); // all fields equal (R7)
        m_imem[7]  = enc(2'b00, 2'd2, 2'd3, 2'd0, 8'hF0); // address wraps (R5)
        m_imem[8]  = enc(2'b10, 2'd3, 2'd3, 2'd3, 8'hFF); // self subtract gives 0 (R4)
        m_imem[9]  = enc(2'b01, 2'd2, 2'd2, 2'd1, 8'hFF); // store Rd == Rn (R6, R7)
        m_imem[10] = enc(2'b00, 2'd3, 2'd2, 2'd0, 8'hFF);
        m_imem[11] = enc(2'b10, 2'd1, 2'd0, 2'd1, 8'h00);
        lcg = 32'h1234_5678;
        for (int i = 12; i < 256; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            m_imem[i] = lcg[23:8];
        end
        for (int i = 0; i < 256; i++) begin
            m_dmem[i] = 8'(i * 37 + 11);
        end
        m_dmem[8'h10] = 8'h05;
        m_dmem[8'h11] = 8'hFA;
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_pc = '0;

        // reset state
        repeat (2) @(negedge clk);
        check_zero("R1/R9 reset");

        // preload during reset (R8)
        for (int i = 0; i < 256; i++) begin
            imem_ld_we   = 1'b1;
            imem_ld_addr = 8'(i);
            imem_ld_data = m_imem[i];
            dmem_ld_we   = 1'b1;
            dmem_ld_addr = 8'(i);
            dmem_ld_data = m_dmem[i];
            @(negedge clk);
        end
        imem_ld_we = 1'b0;
        dmem_ld_we = 1'b0;
        @(negedge clk);

        for (int s = 0; s < NSTEPS; s++) drive_step(s);

        // release, then drive preload writes that must be ignored (R8)
        rst          = 1'b0;
        imem_ld_we   = 1'b1;
        imem_ld_addr = 8'd3;
        imem_ld_data = 16'hC000;
        dmem_ld_we   = 1'b1;
        dmem_ld_addr = 8'h25;
        dmem_ld_data = 8'h99;
        @(posedge clk);
        mon_en = 1'b1;
        repeat (40) @(negedge clk);
        imem_ld_we = 1'b0;
        dmem_ld_we = 1'b0;
        repeat (NSTEPS - 40) @(negedge clk);
        #6;
        mon_en = 1'b0;
        chk("R2 all expected items consumed", q.size(), 0);

        // reset again mid-run (R1)
        rst = 1'b1;
        @(negedge clk);
        check_zero("R1 rerun reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule